// File: doc/BRIEF.md
# Write Endpoint with Lagging Ready and Partial Flags

This block is the receiving end of a synchronous slave FIFO as seen by an external master. The master offers one 32-bit word per clock on a write strobe. The block stores each word in a single buffer of parameterised depth and counts the words that still fit. It reports its state on two flags, where high means "go on". The ready flag is high while at least one word still fits. The partial flag is high while more than a watermark-derived number of words still fit.

Both flags run through a fixed three-register pipeline, so a master always looks at status that is three clocks old. The threshold of the partial flag is set so that this lag is covered. The threshold in words is `WMARK * (32 / DATA_W)`. Suppose the master writes on every clock and keeps writing on the edge where it first samples the partial flag low. After that edge it may write exactly threshold − 4 more words. With the default watermark of 4 that is zero.

When the last word lands, the buffer is committed and `drain_req` rises. A consumer may read the stored words through a registered read port. It then returns the buffer with `drain_ack`, which makes the whole depth free again. A write that finds no space is dropped and sets a sticky error bit.

Top module: `wm_wr_endpoint`

## Requirements
- R1: While reset is asserted (asynchronous, active low, with the inner release two clocks later), `flag_rdy` and `flag_part` are 1, `drain_req` is 0 and `ovf_err` is 0, and the buffer is empty with DEPTH words free.
- R2: A write with at least one word free is accepted and lowers the free count by one. `drain_req` reads 1 right after the edge that accepts the DEPTH-th word since the last refill, and stays 1 until refilled.
- R3: `flag_rdy` equals "free count > 0" as it stood three rising edges earlier.
- R4: `flag_part` equals "free count > WMARK*(32/DATA_W)" as it stood three rising edges earlier. With defaults, the threshold is 4 words.
- R5: Under back-to-back writes from an empty buffer, the master keeps writing on the edge at which it first samples `flag_part` low. After that edge it may write exactly WMARK*(32/DATA_W) − 4 more words before the buffer is full. For defaults, that edge fills the buffer, having made DEPTH writes.
- R6: A write while no word is free is discarded and leaves the free count unchanged. It sets `ovf_err`, visible after that edge, and `ovf_err` stays 1 until reset.
- R7: `drain_ack` while `drain_req` is 1 restores DEPTH free words, so `drain_req` is 0 after that edge and both flags read 1 three edges later. `drain_ack` while `drain_req` is 0 has no effect.
- R8: A write and `drain_ack` on the same edge while the buffer is full count as an overflow (R6) and a refill (R7). The word is not stored, and the count after that edge is DEPTH.
- R9: Words take buffer positions 0, 1, 2, … in order of acceptance since the last refill or reset. `rd_data` after an edge holds the word at the position on `rd_addr` before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per clock |
| wr_data | input | DATA_W | Word to store |
| drain_ack | input | 1 | Consumer returns the full buffer |
| rd_addr | input | $clog2(DEPTH) | Buffer position to read |
| flag_rdy | output | 1 | Lagged "space left" flag |
| flag_part | output | 1 | Lagged "above watermark" flag |
| drain_req | output | 1 | Buffer committed and full |
| ovf_err | output | 1 | Sticky dropped-write error |
| rd_data | output | DATA_W | Registered read data |

## Verification
A write can meet a refill in the same cycle. A master that keeps strobing into a full buffer collides with the consumer's acknowledge. The bench forces this edge on purpose, and the random phases produce it again with writes mixed into the acknowledge cycles. The result is judged at the ports. `ovf_err` must rise and `drain_req` must fall after that edge. Both flags must come back three edges later. Read-back then shows that the next accepted word lands at position 0, not the dropped one.

// File: rtl/ep_pkg.sv
package ep_pkg;

  typedef struct packed {
    logic rdy;
    logic part;
  } ep_flags_t;

  localparam ep_flags_t EP_FLAGS_IDLE = '{rdy: 1'b1, part: 1'b1};

  function automatic int ep_thr_words(input int wmark, input int bus_w);
    return wmark * (32 / bus_w);
  endfunction

endpackage

// File: rtl/ep_space_ctr.sv
module ep_space_ctr
  import ep_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int THR   = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          drain_ack,
  output logic [CW-1:0] free_cnt,
  output logic          wr_take,
  output logic          drain_req,
  output logic          ovf_err,
  output ep_flags_t     raw_flags
);

  logic [CW-1:0] free_q, free_d;
  logic          ovf_q, ovf_d;
  logic          full;

  always_comb begin
    full    = (free_q == '0);
    wr_take = wr_en && !full;
    free_d  = free_q;
    if (full && drain_ack) begin
      free_d = CW'(DEPTH);
    end else if (wr_take) begin
      free_d = free_q - CW'(1);
    end
    ovf_d          = ovf_q | (wr_en && full);
    raw_flags.rdy  = !full;
    raw_flags.part = (free_q > CW'(THR));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= CW'(DEPTH);
      ovf_q  <= 1'b0;
    end else begin
      free_q <= free_d;
      ovf_q  <= ovf_d;
    end
  end

  assign free_cnt  = free_q;
  assign drain_req = full;
  assign ovf_err   = ovf_q;

endmodule

// File: rtl/ep_flag_pipe.sv
module ep_flag_pipe
  import ep_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  ep_flags_t d,
  output ep_flags_t q
);

  ep_flags_t st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    ep_flags_t nxt;
    if (i == 0) begin : g_head
      assign nxt = d;
    end else begin : g_body
      assign nxt = st[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st[i] <= EP_FLAGS_IDLE;
      end else begin
        st[i] <= nxt;
      end
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/ep_store.sv
module ep_store #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/wm_wr_endpoint.sv
module wm_wr_endpoint
  import ep_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32,
  parameter int WMARK  = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int THR   = ep_thr_words(WMARK, DATA_W),
  localparam int LAT   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              drain_ack,
  input  logic [AW-1:0]     rd_addr,
  output logic              flag_rdy,
  output logic              flag_part,
  output logic              drain_req,
  output logic              ovf_err,
  output logic [DATA_W-1:0] rd_data
);

  logic [1:0]    rst_sync;
  logic          rst_core_n;
  logic [CW-1:0] free_cnt;
  logic          wr_take;
  logic [AW-1:0] wr_addr;
  ep_flags_t     raw_flags, out_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync[1];

  ep_space_ctr #(.DEPTH(DEPTH), .THR(THR)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en     (wr_en),
    .drain_ack (drain_ack),
    .free_cnt  (free_cnt),
    .wr_take   (wr_take),
    .drain_req (drain_req),
    .ovf_err   (ovf_err),
    .raw_flags (raw_flags)
  );

  assign wr_addr = AW'(CW'(DEPTH) - free_cnt);

  ep_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .we    (wr_take),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  ep_flag_pipe #(.STAGES(LAT)) u_pipe (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (raw_flags),
    .q     (out_flags)
  );

  assign flag_rdy  = out_flags.rdy;
  assign flag_part = out_flags.part;

endmodule

// File: rtl/wm_wr_endpoint_chk.sv
module wm_wr_endpoint_chk #(
  parameter int DEPTH = 1024,
  parameter int THR   = 4,
  parameter int CW    = 11
) (
  input logic          clk,
  input logic          rst_core_n,
  input logic          wr_en,
  input logic          drain_ack,
  input logic          drain_req,
  input logic          ovf_err,
  input logic          flag_rdy,
  input logic          flag_part,
  input logic [CW-1:0] free_cnt
);

  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      age <= 2'd0;
    end else if (age != 2'd3) begin
      age <= age + 2'd1;
    end
  end

  // R1: count never above the buffer depth
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_core_n)
    free_cnt <= CW'(DEPTH));

  a_r2_write_takes_one: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && free_cnt != '0) |=> (free_cnt == $past(free_cnt) - CW'(1)));

  a_r3_ready_lag: assert property (@(posedge clk) disable iff (!rst_core_n)
    (age == 2'd3) |-> (flag_rdy == $past(free_cnt != '0, 3)));

  a_r4_partial_lag: assert property (@(posedge clk) disable iff (!rst_core_n)
    (age == 2'd3) |-> (flag_part == $past(free_cnt > CW'(THR), 3)));

  a_r6_overflow_set: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && drain_req) |=> ovf_err);

  a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_core_n)
    ovf_err |=> ovf_err);

  a_r7_refill: assert property (@(posedge clk) disable iff (!rst_core_n)
    (drain_req && drain_ack) |=> (free_cnt == CW'(DEPTH)));

  a_r7_idle_ack: assert property (@(posedge clk) disable iff (!rst_core_n)
    (drain_ack && !drain_req && !wr_en) |=> $stable(free_cnt));

endmodule

bind wm_wr_endpoint wm_wr_endpoint_chk #(.DEPTH(DEPTH), .THR(THR), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .wr_en      (wr_en),
  .drain_ack  (drain_ack),
  .drain_req  (drain_req),
  .ovf_err    (ovf_err),
  .flag_rdy   (flag_rdy),
  .flag_part  (flag_part),
  .free_cnt   (free_cnt)
);

// File: tb/sim_wm_wr_endpoint.sv
module sim_wm_wr_endpoint;

  localparam int CLK_P = 10;
  localparam int D     = 1024;
  localparam int THR   = 4;
  localparam int AW    = $clog2(D);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, drain_ack;
  logic [31:0] wr_data;
  logic [AW-1:0] rd_addr;
  logic        flag_rdy, flag_part, drain_req, ovf_err;
  logic [31:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int          free_m;
  bit          ovf_m;
  logic [2:0]  rdy_sh, part_sh;
  logic [31:0] mem_m [D];
  logic [31:0] exp_rd;

  always #(CLK_P/2) clk = ~clk;

  wm_wr_endpoint u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .drain_ack(drain_ack), .rd_addr(rd_addr), .flag_rdy(flag_rdy),
    .flag_part(flag_part), .drain_req(drain_req), .ovf_err(ovf_err),
    .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_part(input int f);
    return f > THR;
  endfunction

  task automatic model_reset();
    free_m  = D;
    ovf_m   = 1'b0;
    rdy_sh  = 3'b111;
    part_sh = 3'b111;
  endtask

  task automatic model_edge(input logic we, input logic [31:0] d, input logic ack, input int ra);
    bit full;
    full    = (free_m == 0);
    exp_rd  = mem_m[ra];
    rdy_sh  = {rdy_sh[1:0], !full};
    part_sh = {part_sh[1:0], exp_part(free_m)};
    if (we && !full) mem_m[D - free_m] = d;
    if (we && full) ovf_m = 1'b1;
    if (full && ack) free_m = D;
    else if (we && !full) free_m--;
  endtask

  task automatic step(input logic we, input logic [31:0] d, input logic ack,
                      input int ra, input bit check_rd);
    wr_en = we; wr_data = d; drain_ack = ack; rd_addr = AW'(ra);
    model_edge(we, d, ack, ra);
    @(posedge clk);
    @(negedge clk);
    chk("R3 flag_rdy", 32'(flag_rdy), 32'(rdy_sh[2]));
    chk("R4 flag_part", 32'(flag_part), 32'(part_sh[2]));
    chk("R2 drain_req", 32'(drain_req), 32'(free_m == 0));
    chk("R6 ovf_err", 32'(ovf_err), 32'(ovf_m));
    if (check_rd) chk("R9 rd_data", rd_data, exp_rd);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; drain_ack = 1'b0; wr_data = '0; rd_addr = '0;
    model_reset();
    #1;
    chk("R1 flag_rdy in reset", 32'(flag_rdy), 32'd1);
    chk("R1 flag_part in reset", 32'(flag_part), 32'd1);
    chk("R1 drain_req in reset", 32'(drain_req), 32'd0);
    chk("R1 ovf_err in reset", 32'(ovf_err), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0, 0, 1'b0);
  endtask

  task automatic random_fill(input int wr_pct);
    int guard = 0;
    while (free_m != 0 && guard < 20000) begin
      step(($urandom % 100) < wr_pct, $urandom, ($urandom % 8) == 0, 0, 1'b0);
      guard++;
    end
  endtask

  task automatic drain_with_reads(input int n_reads, input bit poke_wr);
    for (int i = 0; i < n_reads; i++) begin
      step(1'b0, '0, 1'b0, int'($urandom % D), 1'b1);
    end
    step(poke_wr, $urandom, 1'b1, 0, 1'b0);
    chk("R7 drain_req after ack", 32'(drain_req), 32'd0);
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b0, 0, 1'b0);
    chk("R7 flag_rdy back", 32'(flag_rdy), 32'd1);
    chk("R7 flag_part back", 32'(flag_part), 32'd1);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    @(negedge clk);
    do_reset();

    // R2 / R9: random fill, then read back and refill
    random_fill(65);
    chk("R2 full after random fill", 32'(drain_req), 32'd1);
    drain_with_reads(6, 1'b0);

    // R7: acknowledge while not full is ignored
    step(1'b0, '0, 1'b1, 0, 1'b0);
    step(1'b0, '0, 1'b1, 0, 1'b0);

    // R5: back-to-back writes, stop after edge where flag_part was sampled low
    begin
      int  n = 0;
      bit  s;
      do begin
        s = flag_part;
        step(1'b1, $urandom, 1'b0, 0, 1'b0);
        n++;
      end while (s && n < 2 * D);
      chk("R5 writes until partial seen low", 32'(n), 32'(D));
      chk("R5 remaining after low sample is zero", 32'(drain_req), 32'd1);
      chk("R5 no overflow", 32'(ovf_err), 32'd0);
    end

    // R9: read back a few words of the full buffer
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0, int'($urandom % D), 1'b1);
    step(1'b0, '0, 1'b0, D - 1, 1'b1);

    // R8: write and acknowledge in the same cycle while full
    step(1'b1, 32'hDEAD_BEEF, 1'b1, 0, 1'b0);
    chk("R8 overflow on collision", 32'(ovf_err), 32'd1);
    chk("R8 refilled on collision", 32'(drain_req), 32'd0);
    step(1'b1, 32'h0000_A5A5, 1'b0, 0, 1'b0);
    step(1'b0, '0, 1'b0, 0, 1'b1);
    chk("R8 first word after refill at position 0", rd_data, 32'h0000_A5A5);
    step(1'b0, '0, 1'b0, 0, 1'b0);
    chk("R7 flags back after collision", 32'(flag_rdy), 32'd1);

    // R6: writes into a full buffer, random acks, several fills
    for (int k = 0; k < 3; k++) begin
      random_fill(85);
      for (int i = 0; i < 3; i++) step(1'b1, $urandom, 1'b0, 0, 1'b0);
      chk("R6 dropped writes keep buffer full", 32'(drain_req), 32'd1);
      drain_with_reads(3, k[0]);
    end

    // R1 / R6: reset mid-fill clears the sticky error
    for (int i = 0; i < 20; i++) step(1'b1, $urandom, 1'b0, 0, 1'b0);
    @(negedge clk);
    do_reset();
    chk("R6 sticky error cleared by reset", 32'(ovf_err), 32'd0);
    chk("R1 buffer empty after reset", 32'(drain_req), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule